// File: doc/BRIEF.md
# AUX Transfer Retry Sequencer

This block carries one AUX request from a simple requester through a channel register bank and back. A start strobe hands over the bytes to send, the send length and the receive capacity. The sequencer first makes sure that no earlier activity is still holding the channel and then checks the two lengths. It then runs attempts: it loads the message, starts the channel and waits for the busy flag to drop. After each attempt it writes the status back so that the sticky flags are cleared, and it sorts the outcome into one of several classes.

Retries are nested. An outer loop walks a parameterised list of bit-clock divider values, and an inner loop makes up to five attempts with each value. A timeout retries at once. A receive error waits for a guard interval before the next attempt. A watchdog abandons an attempt that never completes. All delays come from a microsecond timer with a prescaler, and the timer's clock frequency and delay lengths are parameters, so a simulation can shorten them. The line-level transceiver sits outside this block.

Top module: `aux_xfer_seq`

## Requirements
- R1: After reset, `rsp_valid`, `ch_start` and `ch_clear` are low and `rsp_code` reads 0.
- R2: The channel busy flag is sampled up to 3 times, with POLL_GAP_US between samples. If it is still set at the third sample, the result is busy (code 1) and `ch_start` never pulses. If it clears earlier, the transfer proceeds.
- R3: A send length or a receive capacity above 20 gives too-large (code 2) with no attempt started.
- R4: Divider entries are used in ascending index order, each attempt presenting the current entry on `ch_div`. The list ends at the first zero entry; with the default table that means 63 and then 72.
- R5: At most 5 attempts are made per divider entry, so the default table allows 10 attempts in all.
- R6: Every attempt is followed by exactly one `ch_clear` pulse before the next `ch_start` or the response.
- R7: A completion with the timeout flag set starts the next attempt within 5 cycles of busy falling.
- R8: A completion with the receive-error flag set (and no timeout) delays the next attempt by at least RX_GAP_US.
- R9: A completion with done set and neither error flag gives success (code 0). `rsp_rx_len` is the smaller of the received count and the capacity, and `rsp_rx_data` byte i (bits 8i+7:8i) holds received byte i below that length and zero above it.
- R10: A successful completion whose received count is 0 or above 20 gives busy (code 1).
- R11: An attempt whose busy flag is still high after WDOG_US is abandoned, cleared and retried.
- R12: When all attempts are used up, the last status decides the code: done with receive error gives 3, done with timeout gives 4, anything else gives busy (1).
- R13: `req_start` is ignored while a transfer is in progress.
- R14: Each request produces exactly one response: `rsp_valid` high for a single cycle, with the code, length and data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_tx_len | input | LEN_W | Bytes to send |
| req_rx_cap | input | LEN_W | Receive capacity in bytes |
| req_tx_data | input | 8*MAX_BYTES | Send bytes, byte i at bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 3 | 0 ok, 1 busy, 2 too large, 3 receive error, 4 timeout |
| rsp_rx_len | output | LEN_W | Bytes delivered |
| rsp_rx_data | output | 8*MAX_BYTES | Delivered bytes, zero above length |
| ch_busy | input | 1 | Channel busy flag |
| ch_done | input | 1 | Channel done flag |
| ch_tmo_err | input | 1 | Channel timeout flag |
| ch_rx_err | input | 1 | Channel receive-error flag |
| ch_rx_len | input | LEN_W | Byte count received by the channel |
| ch_rx_data | input | 8*MAX_BYTES | Bytes received by the channel |
| ch_start | output | 1 | One-cycle attempt start |
| ch_clear | output | 1 | One-cycle status write-back clearing the flags |
| ch_div | output | DIV_W | Bit-clock divider for this attempt |
| ch_tx_len | output | LEN_W | Send length presented to the channel |
| ch_tx_data | output | 8*MAX_BYTES | Send bytes presented to the channel |

## Verification
The embedded properties watch, on every cycle, that a clear follows each completion, that the attempt counter stays below five, that the divider value is never zero at a start, that a timeout leads straight into the next start, that a receive-error gap blocks starts until the timer runs out, and that the response strobe lasts one cycle. The orderings that depend on how the channel answers can only be shown by the bench's scenarios: the divider sequence across attempts, the minimum receive-error gap, watchdog recovery, the code left after exhaustion, the length truncation and the byte masking, and the handling of a channel that is already busy at start.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    localparam int AUX_MAX_BYTES = 20;
    localparam int AUX_ATTEMPTS  = 5;
    localparam int AUX_POLLS     = 3;

    typedef enum logic [2:0] {
        RES_OK     = 3'd0,
        RES_BUSY   = 3'd1,
        RES_TOOBIG = 3'd2,
        RES_RXERR  = 3'd3,
        RES_TMO    = 3'd4
    } aux_res_e;

    typedef struct packed {
        logic done;
        logic tmo;
        logic rxe;
    } aux_stat_t;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL, S_PGAP, S_CHECK, S_DSEL, S_SEND,
        S_ARM, S_WAIT, S_CLR, S_RGAP, S_NEXT, S_DONE
    } aux_state_e;

    // Code reported once every attempt has been used up.
    function automatic aux_res_e exhaust_code(aux_stat_t s);
        if (s.done && s.rxe) return RES_RXERR;
        if (s.done && s.tmo) return RES_TMO;
        return RES_BUSY;
    endfunction

endpackage

// File: rtl/aux_us_timer.sv
module aux_us_timer #(
    parameter int CLK_HZ = 100_000_000,
    parameter int CNT_W  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_us,
    output logic             expired
);
    localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int PRE_W      = $clog2(CYC_PER_US + 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] rem_q;
    logic             tick;

    assign tick    = (pre_q == PRE_W'(CYC_PER_US - 1));
    assign expired = (rem_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            rem_q <= load_us;
        end else if (rem_q != '0) begin
            if (tick) begin
                pre_q <= '0;
                rem_q <= rem_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R11: the delay count never rises unless it is reloaded
    a_r11_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && rem_q != '0) |=> (rem_q <= $past(rem_q)));

endmodule

// File: rtl/aux_div_sel.sv
module aux_div_sel #(
    parameter int NUM_DIV = 3,
    parameter int DIV_W   = 8,
    parameter int IDX_W   = 2,
    parameter logic [NUM_DIV*DIV_W-1:0] TABLE = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [DIV_W-1:0] value
);
    logic [DIV_W-1:0] ent [NUM_DIV];

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_ent
        assign ent[g] = TABLE[g*DIV_W +: DIV_W];
    end

    // An index past the end reads as zero, which ends the list.
    always_comb begin
        value = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (idx == IDX_W'(i)) value = ent[i];
        end
    end

endmodule

// File: rtl/aux_rx_trim.sv
module aux_rx_trim #(
    parameter int MAX_BYTES = 20,
    parameter int LEN_W     = 5
) (
    input  logic [LEN_W-1:0]       rx_len,
    input  logic [LEN_W-1:0]       cap,
    input  logic [8*MAX_BYTES-1:0] rx_data,
    output logic                   len_bad,
    output logic [LEN_W-1:0]       eff_len,
    output logic [8*MAX_BYTES-1:0] eff_data
);
    assign len_bad = (rx_len == '0) || (rx_len > LEN_W'(MAX_BYTES));
    assign eff_len = (rx_len > cap) ? cap : rx_len;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
        assign eff_data[8*g +: 8] = (LEN_W'(g) < eff_len) ? rx_data[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/aux_xfer_seq.sv
module aux_xfer_seq
    import aux_seq_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int POLL_GAP_US = 1000,
    parameter int RX_GAP_US   = 450,
    parameter int WDOG_US     = 10000,
    parameter int MAX_BYTES   = AUX_MAX_BYTES,
    parameter int LEN_W       = $clog2(MAX_BYTES + 1),
    parameter int NUM_DIV     = 3,
    parameter int DIV_W       = 8,
    parameter logic [NUM_DIV*DIV_W-1:0] DIV_TABLE = {8'd0, 8'd72, 8'd63}
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_start,
    input  logic [LEN_W-1:0]       req_tx_len,
    input  logic [LEN_W-1:0]       req_rx_cap,
    input  logic [8*MAX_BYTES-1:0] req_tx_data,
    output logic                   rsp_valid,
    output logic [2:0]             rsp_code,
    output logic [LEN_W-1:0]       rsp_rx_len,
    output logic [8*MAX_BYTES-1:0] rsp_rx_data,
    input  logic                   ch_busy,
    input  logic                   ch_done,
    input  logic                   ch_tmo_err,
    input  logic                   ch_rx_err,
    input  logic [LEN_W-1:0]       ch_rx_len,
    input  logic [8*MAX_BYTES-1:0] ch_rx_data,
    output logic                   ch_start,
    output logic                   ch_clear,
    output logic [DIV_W-1:0]       ch_div,
    output logic [LEN_W-1:0]       ch_tx_len,
    output logic [8*MAX_BYTES-1:0] ch_tx_data
);
    localparam int TMR_A   = (POLL_GAP_US > RX_GAP_US) ? POLL_GAP_US : RX_GAP_US;
    localparam int TMR_MAX = (TMR_A > WDOG_US) ? TMR_A : WDOG_US;
    localparam int CNT_W   = $clog2(TMR_MAX + 1);
    localparam int IDX_W   = $clog2(NUM_DIV + 1);
    localparam int ATT_W   = $clog2(AUX_ATTEMPTS);
    localparam int POLL_W  = $clog2(AUX_POLLS);

    aux_state_e             state_q;
    aux_stat_t              st_q;
    aux_res_e               code_q;
    logic [POLL_W-1:0]      poll_q;
    logic [ATT_W-1:0]       att_q;
    logic [IDX_W-1:0]       idx_q;
    logic [LEN_W-1:0]       tx_len_q, cap_q, rx_len_q, rsp_len_q;
    logic [8*MAX_BYTES-1:0] tx_data_q, rx_data_q, rsp_data_q;

    logic                   tmr_load, tmr_exp;
    logic [CNT_W-1:0]       tmr_val;
    logic [DIV_W-1:0]       div_val;
    logic                   len_bad;
    logic [LEN_W-1:0]       eff_len;
    logic [8*MAX_BYTES-1:0] eff_data;
    logic                   last_poll, last_att;

    aux_us_timer #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_us(tmr_val), .expired(tmr_exp));

    aux_div_sel #(.NUM_DIV(NUM_DIV), .DIV_W(DIV_W), .IDX_W(IDX_W), .TABLE(DIV_TABLE)) u_div (
        .idx(idx_q), .value(div_val));

    aux_rx_trim #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_trim (
        .rx_len(rx_len_q), .cap(cap_q), .rx_data(rx_data_q),
        .len_bad(len_bad), .eff_len(eff_len), .eff_data(eff_data));

    assign last_poll = (poll_q == POLL_W'(AUX_POLLS - 1));
    assign last_att  = (att_q == ATT_W'(AUX_ATTEMPTS - 1));

    // One timer serves the poll gap, the attempt watchdog and the receive-error gap.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_POLL: if (ch_busy && !last_poll) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(POLL_GAP_US);
            end
            S_SEND: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WDOG_US);
            end
            S_CLR: if (!st_q.tmo && st_q.rxe) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RX_GAP_US);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            st_q       <= '0;
            code_q     <= RES_OK;
            poll_q     <= '0;
            att_q      <= '0;
            idx_q      <= '0;
            tx_len_q   <= '0;
            cap_q      <= '0;
            rx_len_q   <= '0;
            rsp_len_q  <= '0;
            tx_data_q  <= '0;
            rx_data_q  <= '0;
            rsp_data_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_start) begin
                    tx_len_q  <= req_tx_len;
                    cap_q     <= req_rx_cap;
                    tx_data_q <= req_tx_data;
                    poll_q    <= '0;
                    state_q   <= S_POLL;
                end
                S_POLL: begin
                    if (!ch_busy) begin
                        state_q <= S_CHECK;
                    end else if (last_poll) begin
                        code_q     <= RES_BUSY;
                        rsp_len_q  <= '0;
                        rsp_data_q <= '0;
                        state_q    <= S_DONE;
                    end else begin
                        poll_q  <= poll_q + 1'b1;
                        state_q <= S_PGAP;
                    end
                end
                S_PGAP: if (tmr_exp) state_q <= S_POLL;
                S_CHECK: begin
                    if (tx_len_q > LEN_W'(MAX_BYTES) || cap_q > LEN_W'(MAX_BYTES)) begin
                        code_q     <= RES_TOOBIG;
                        rsp_len_q  <= '0;
                        rsp_data_q <= '0;
                        state_q    <= S_DONE;
                    end else begin
                        idx_q   <= '0;
                        st_q    <= '0;
                        state_q <= S_DSEL;
                    end
                end
                S_DSEL: begin
                    if (div_val == '0) begin
                        code_q     <= exhaust_code(st_q);
                        rsp_len_q  <= '0;
                        rsp_data_q <= '0;
                        state_q    <= S_DONE;
                    end else begin
                        att_q   <= '0;
                        state_q <= S_SEND;
                    end
                end
                S_SEND: state_q <= S_ARM;
                S_ARM:  state_q <= S_WAIT;
                S_WAIT: begin
                    if (!ch_busy) begin
                        st_q      <= '{done: ch_done, tmo: ch_tmo_err, rxe: ch_rx_err};
                        rx_len_q  <= ch_rx_len;
                        rx_data_q <= ch_rx_data;
                        state_q   <= S_CLR;
                    end else if (tmr_exp) begin
                        st_q    <= '0;
                        state_q <= S_CLR;
                    end
                end
                S_CLR: begin
                    if (st_q.tmo) begin
                        state_q <= S_NEXT;
                    end else if (st_q.rxe) begin
                        state_q <= S_RGAP;
                    end else if (st_q.done) begin
                        code_q     <= len_bad ? RES_BUSY : RES_OK;
                        rsp_len_q  <= len_bad ? '0 : eff_len;
                        rsp_data_q <= len_bad ? '0 : eff_data;
                        state_q    <= S_DONE;
                    end else begin
                        state_q <= S_NEXT;
                    end
                end
                S_RGAP: if (tmr_exp) state_q <= S_NEXT;
                S_NEXT: begin
                    if (last_att) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_DSEL;
                    end else begin
                        att_q   <= att_q + 1'b1;
                        state_q <= S_SEND;
                    end
                end
                S_DONE: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign ch_start    = (state_q == S_SEND);
    assign ch_clear    = (state_q == S_CLR);
    assign ch_div      = div_val;
    assign ch_tx_len   = tx_len_q;
    assign ch_tx_data  = tx_data_q;
    assign rsp_valid   = (state_q == S_DONE);
    assign rsp_code    = code_q;
    assign rsp_rx_len  = rsp_len_q;
    assign rsp_rx_data = rsp_data_q;

    // R6: a completion seen by the sequencer is cleared in the next cycle
    a_r6_clear_after_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && !ch_busy) |=> ch_clear);

    // R5: never more than the allowed attempts per divider entry
    a_r5_attempt_bound: assert property (@(posedge clk) disable iff (rst)
        att_q <= ATT_W'(AUX_ATTEMPTS - 1));

    // R4: a start never uses a zero divider
    a_r4_div_nonzero: assert property (@(posedge clk) disable iff (rst)
        ch_start |-> (ch_div != '0));

    // R7: a timeout with attempts left goes straight to the next start
    a_r7_tmo_restart: assert property (@(posedge clk) disable iff (rst)
        (ch_clear && st_q.tmo && !last_att) |=> ##1 ch_start);

    // R8: no start while the receive-error gap is running
    a_r8_gap_blocks: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RGAP && !tmr_exp) |=> !ch_start);

    // R14: the response strobe lasts a single cycle
    a_r14_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9: a successful length never exceeds the capacity
    a_r9_len_cap: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == RES_OK) |-> (rsp_rx_len <= cap_q));

    // R3: an oversized request never starts the channel
    a_r3_toobig_nostart: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CHECK && tx_len_q > LEN_W'(MAX_BYTES)) |=> !ch_start);

endmodule

// File: tb/test_aux_xfer_seq.sv
module test_aux_xfer_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB  = 20;
    localparam int LW    = 5;
    localparam int PGAP  = 50;
    localparam int RGAP  = 40;
    localparam int WDOG  = 100;
    localparam int NATT  = 10;
    localparam int OC_OK = 0, OC_TMO = 1, OC_RXE = 2, OC_HANG = 3, OC_TMOND = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_start = 1'b0;
    logic [LW-1:0] req_tx_len = '0, req_rx_cap = '0;
    logic [8*MAXB-1:0] req_tx_data = '0;
    logic rsp_valid;
    logic [2:0] rsp_code;
    logic [LW-1:0] rsp_rx_len;
    logic [8*MAXB-1:0] rsp_rx_data;
    logic ch_busy, ch_done, ch_tmo_err, ch_rx_err;
    logic [LW-1:0] ch_rx_len;
    logic [8*MAXB-1:0] ch_rx_data;
    logic ch_start, ch_clear;
    logic [7:0] ch_div;
    logic [LW-1:0] ch_tx_len;
    logic [8*MAXB-1:0] ch_tx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_xfer_seq #(.CLK_HZ(1_000_000), .POLL_GAP_US(PGAP), .RX_GAP_US(RGAP), .WDOG_US(WDOG))
    i_aux_xfer_seq (
        .clk(clk), .rst(rst), .req_start(req_start), .req_tx_len(req_tx_len),
        .req_rx_cap(req_rx_cap), .req_tx_data(req_tx_data), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_rx_len(rsp_rx_len), .rsp_rx_data(rsp_rx_data),
        .ch_busy(ch_busy), .ch_done(ch_done), .ch_tmo_err(ch_tmo_err), .ch_rx_err(ch_rx_err),
        .ch_rx_len(ch_rx_len), .ch_rx_data(ch_rx_data), .ch_start(ch_start),
        .ch_clear(ch_clear), .ch_div(ch_div), .ch_tx_len(ch_tx_len), .ch_tx_data(ch_tx_data));

    // Channel model
    int outc [NATT];
    int cyc = 0, base = 0, n_starts = 0, n_clears = 0, lat = 0, cur = 0, sidx = 0;
    int start_t [16], end_t [16], start_div [16], start_txl [16];
    logic run_busy = 1'b0, pre_busy = 1'b0, cdone = 1'b0, ctmo = 1'b0, crx = 1'b0;
    logic [LW-1:0] clen_drv = '0;
    logic [8*MAXB-1:0] chan_data = '0;

    assign ch_busy    = run_busy | pre_busy;
    assign ch_done    = cdone;
    assign ch_tmo_err = ctmo;
    assign ch_rx_err  = crx;
    assign ch_rx_len  = clen_drv;
    assign ch_rx_data = chan_data;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (rst) begin
            run_busy <= 1'b0; cdone <= 1'b0; ctmo <= 1'b0; crx <= 1'b0;
        end else if (ch_start) begin
            sidx = n_starts - base;
            run_busy <= 1'b1; lat <= 6;
            cur <= outc[(sidx < NATT) ? sidx : NATT-1];
            cdone <= 1'b0; ctmo <= 1'b0; crx <= 1'b0;
            if (sidx < 16) begin
                start_t[sidx] <= cyc; start_div[sidx] <= int'(ch_div);
                start_txl[sidx] <= int'(ch_tx_len);
            end
            n_starts <= n_starts + 1;
        end else if (ch_clear) begin
            run_busy <= 1'b0; cdone <= 1'b0; ctmo <= 1'b0; crx <= 1'b0;
            n_clears <= n_clears + 1;
        end else if (run_busy && cur != OC_HANG) begin
            if (lat == 0) begin
                run_busy <= 1'b0;
                cdone <= (cur != OC_TMOND);
                ctmo  <= (cur == OC_TMO || cur == OC_TMOND);
                crx   <= (cur == OC_RXE);
                sidx = n_starts - 1 - base;
                if (sidx >= 0 && sidx < 16) end_t[sidx] <= cyc;
            end else begin
                lat <= lat - 1;
            end
        end
    end

    int total = 0, bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result from the requirements
    function automatic void expect_of(input int txl, input int cap, input int clen, input int pre,
                                      output int code, output int elen, output int natt);
        code = 1; elen = 0; natt = 0;
        if (pre < 0) return;
        if (txl > MAXB || cap > MAXB) begin code = 2; return; end
        for (int k = 0; k < NATT; k++) begin
            natt = k + 1;
            if (outc[k] == OC_OK) begin
                if (clen == 0 || clen > MAXB) code = 1;
                else begin code = 0; elen = (clen < cap) ? clen : cap; end
                return;
            end
        end
        if (outc[NATT-1] == OC_RXE) code = 3;
        else if (outc[NATT-1] == OC_TMO) code = 4;
        else code = 1;
    endfunction

    task automatic run_case(input int txl, input int cap, input int clen, input int pre, input bit mid);
        int ecode, elen, enatt, waited, nrsp, natt, ncl, gcode, glen;
        logic [8*MAXB-1:0] gdata, edata;
        bit ok;
        expect_of(txl, cap, clen, pre, ecode, elen, enatt);
        @(negedge clk);
        base = n_starts;
        ncl = n_clears;
        clen_drv = LW'(clen);
        for (int w = 0; w < MAXB/4; w++) chan_data[32*w +: 32] = $urandom;
        req_tx_len = LW'(txl); req_rx_cap = LW'(cap);
        for (int w = 0; w < MAXB/4; w++) req_tx_data[32*w +: 32] = $urandom;
        pre_busy = (pre != 0);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        waited = 0; nrsp = 0; gcode = 7; glen = 0; gdata = '0;
        while (waited < 20000 && nrsp == 0) begin
            if (pre > 0 && waited == pre) pre_busy = 1'b0;
            if (mid && waited == 20) begin req_start = 1'b1; req_tx_len = 5'd3; end
            else req_start = 1'b0;
            if (rsp_valid) begin
                nrsp++; gcode = int'(rsp_code); glen = int'(rsp_rx_len); gdata = rsp_rx_data;
            end
            @(negedge clk);
            waited++;
        end
        req_start = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (rsp_valid) nrsp++;
            @(negedge clk);
        end
        pre_busy = 1'b0;
        natt = n_starts - base;
        check(nrsp == 1, "R14 one response pulse", nrsp, 1);
        if (pre < 0)
            check(gcode == ecode, "R2 busy before start", gcode, ecode);
        else if (ecode == 2)
            check(gcode == ecode, "R3 too large", gcode, ecode);
        else if (natt == NATT && ecode != 0)
            check(gcode == ecode, "R12 exhaustion code", gcode, ecode);
        else
            check(gcode == ecode, "R9 R10 result code", gcode, ecode);
        check(natt == enatt, "R5 attempt count", natt, enatt);
        check(n_clears - ncl == natt, "R6 clear per attempt", n_clears - ncl, natt);
        if (ecode == 0) begin
            edata = '0;
            for (int i = 0; i < MAXB; i++) if (i < elen) edata[8*i +: 8] = chan_data[8*i +: 8];
            check(glen == elen, "R9 length", glen, elen);
            check(gdata == edata, "R9 data bytes", gdata[63:0], edata[63:0]);
        end
        ok = 1'b1;
        for (int k = 0; k < natt && k < 16; k++)
            if (start_div[k] != ((k < 5) ? 63 : 72)) ok = 1'b0;
        check(ok, "R4 divider order", start_div[0], 63);
        for (int k = 1; k < natt && k < 16; k++) begin
            if (outc[k-1] == OC_TMO || outc[k-1] == OC_TMOND)
                check(start_t[k] - end_t[k-1] <= 5, "R7 timeout retry", start_t[k] - end_t[k-1], 5);
            else if (outc[k-1] == OC_RXE)
                check(start_t[k] - end_t[k-1] >= RGAP, "R8 receive-error gap", start_t[k] - end_t[k-1], RGAP);
            else if (outc[k-1] == OC_HANG)
                check(start_t[k] - start_t[k-1] >= WDOG, "R11 watchdog", start_t[k] - start_t[k-1], WDOG);
        end
        if (mid) begin
            ok = 1'b1;
            for (int k = 0; k < natt && k < 16; k++) if (start_txl[k] != txl) ok = 1'b0;
            check(ok, "R13 start ignored when busy", start_txl[natt-1], txl);
        end
    endtask

    task automatic fill(input int a, input int b, input int n);
        for (int k = 0; k < NATT; k++) outc[k] = (k < n) ? a : b;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        fill(OC_OK, OC_OK, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !ch_start && !ch_clear && rsp_code == 3'd0, "R1 reset state",
              {rsp_valid, ch_start, ch_clear}, 0);
        run_case(5, 8, 6, 0, 0);                  // R9 first try
        run_case(4, 3, 10, 0, 0);                 // R9 truncation
        run_case(4, 0, 7, 0, 0);                  // R9 zero capacity
        run_case(4, 8, 0, 0, 0);                  // R10 zero count
        run_case(4, 8, 25, 0, 0);                 // R10 count above 20
        run_case(21, 8, 6, 0, 0);                 // R3 send too long
        run_case(4, 21, 6, 0, 0);                 // R3 capacity too large
        run_case(4, 8, 6, -1, 0);                 // R2 channel stays busy
        run_case(4, 8, 6, 30, 0);                 // R2 busy clears before last poll
        fill(OC_TMO, OC_OK, 4);  run_case(6, 8, 8, 0, 0);   // R5 last attempt on first divider
        fill(OC_TMO, OC_OK, 5);  run_case(6, 8, 8, 0, 0);   // R4 second divider
        fill(OC_RXE, OC_RXE, 10); run_case(6, 8, 8, 0, 0);  // R12 receive error
        fill(OC_TMO, OC_TMO, 10); run_case(6, 8, 8, 0, 0);  // R12 timeout
        fill(OC_TMOND, OC_TMOND, 10); run_case(6, 8, 8, 0, 0); // R12 not done
        fill(OC_HANG, OC_OK, 2); run_case(6, 8, 8, 0, 0);   // R11 watchdog
        fill(OC_HANG, OC_OK, 1); run_case(7, 8, 8, 0, 1);   // R13 ignored start
        for (int n = 0; n < 20; n++) begin
            for (int k = 0; k < NATT; k++) begin
                int r;
                r = int'($urandom % 10);
                outc[k] = (r < 4) ? OC_OK : (r < 6) ? OC_TMO : (r < 8) ? OC_RXE : (r < 9) ? OC_TMOND : OC_HANG;
            end
            run_case(int'($urandom % 21), int'($urandom % 21), 1 + int'($urandom % 20), 0, 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

endmodule